// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block steers a successive-approximation converter through its two phases: acquisition, during which the input is tracked, and conversion, during which the modelled converter resolves a result. The block runs on a fast clock at twice the instruction rate. A programmable 6-bit divider turns that clock into conversion-clock ticks. Every phase length is counted in these ticks.

A 3-bit source field selects what ends acquisition and starts conversion. The choices are a software sample bit being cleared, a timer event pulse, an external event pulse, or an automatic count of conversion clocks. In automatic mode the block samples and converts back to back for as long as it stays enabled. A conversion takes a fixed 14 ticks. When it completes, the block captures the converter's digital word into a result buffer and raises a done pulse and a sticky done flag. Dropping the enable at any point abandons the work in progress and leaves the buffer untouched.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset the buffer reads 0, and done, done pulse, sampling and converting are all low. A low enable returns the block to idle (neither sampling nor converting) at the next clock edge.
- R2: A conversion-clock tick occurs once every (clk_sel_i + 1) fast clocks. The divider restarts at each phase boundary. Conversion therefore lasts 14 × (clk_sel_i + 1) fast clocks, and the done pulse is high in the cycle after the last one.
- R3: Source code 000 (software): from idle, a high sample bit starts acquisition. A low sample bit during acquisition starts conversion at the next edge. After the result the block idles until the sample bit is high again.
- R4: Source code 010 accepts only the timer pulse and code 001 accepts only the external pulse, each during acquisition. Codes 011 to 110 never start a conversion.
- R5: Source code 111 (auto): acquisition starts on enable and lasts max(samp_cnt_i, 1) ticks, then conversion starts. Acquisition restarts straight after each result, so consecutive done pulses are (max(samp_cnt_i, 1) + 14) × (clk_sel_i + 1) fast clocks apart.
- R6: A sample count of 0 behaves exactly like a sample count of 1.
- R7: On completion the buffer takes the value of conv_data_i from the final conversion cycle, and done_pulse_o is high for exactly one cycle.
- R8: A low enable during conversion aborts it. No done pulse follows and the buffer keeps its previous contents.
- R9: If the enable is low in the cycle in which the automatic count would start a conversion, no conversion starts.
- R10: done_o is set with each result. It is cleared when acquisition starts from idle, and it stays set through back-to-back automatic cycles.
- R11: A buffer write (buf_wr_i high) loads buf_wdata_i at the next edge. A conversion result in the same cycle wins over the write.
- R12: sampling_o and converting_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the instruction rate |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Converter enable |
| samp_i | input | 1 | Software sample bit |
| src_i | input | 3 | Trigger source select |
| samp_cnt_i | input | SAMC_W | Auto-mode acquisition length in ticks |
| clk_sel_i | input | ADCS_W | Conversion-clock divider select |
| tmr_evt_i | input | 1 | Timer event pulse |
| ext_evt_i | input | 1 | External event pulse |
| conv_data_i | input | RES_W | Digital word from the modelled converter |
| buf_wr_i | input | 1 | Direct buffer write strobe |
| buf_wdata_i | input | RES_W | Direct buffer write data |
| buf_o | output | RES_W | Result buffer |
| done_pulse_o | output | 1 | One-cycle completion pulse |
| done_o | output | 1 | Sticky completion flag |
| sampling_o | output | 1 | Acquisition phase active |
| converting_o | output | 1 | Conversion phase active |

## Verification
The enable clear and the automatic start of conversion can land in the same cycle, and the bench provokes this on purpose. With a one-fast-clock tick and a sample count of 2, it lowers the enable in exactly the cycle in which acquisition expires. It then requires that converting stays low, that no done pulse appears and that the buffer is unchanged. A control run lowers the enable one cycle later and must see converting high first, which confirms that the coincident cycle was really hit. The bench also aims a direct buffer write at the final conversion cycle to judge the priority between result and write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_e;

  localparam logic [2:0] SRC_SOFT = 3'b000;
  localparam logic [2:0] SRC_EXT  = 3'b001;
  localparam logic [2:0] SRC_TMR  = 3'b010;
  localparam logic [2:0] SRC_AUTO = 3'b111;

endpackage

// File: rtl/adc_clkdiv.sv
// Conversion-clock tick generator: one tick per (clk_sel + 1) fast clocks,
// restarted at every phase boundary.
module adc_clkdiv #(
  parameter int ADCS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [ADCS_W-1:0] clk_sel,
  output logic              tick
);

  logic [ADCS_W-1:0] cnt;

  assign tick = run && (cnt >= clk_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_trig_sel.sv
// Decodes the source field into a conversion trigger (not yet gated by enable).
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic [2:0] src,
  input  logic       sampling,
  input  logic       samp,
  input  logic       tmr_evt,
  input  logic       ext_evt,
  input  logic       samp_expire,
  output logic       is_auto,
  output logic       trig,
  output logic       auto_start
);

  assign is_auto    = (src == SRC_AUTO);
  assign auto_start = sampling && is_auto && samp_expire;

  always_comb begin
    case (src)
      SRC_SOFT: trig = sampling && !samp;
      SRC_EXT:  trig = sampling && ext_evt;
      SRC_TMR:  trig = sampling && tmr_evt;
      SRC_AUTO: trig = auto_start;
      default:  trig = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_seq_fsm.sv
// Phase sequencer: idle / acquisition / conversion, with tick counting.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SAMC_W    = 5,
  parameter int CNV_TICKS = 14,
  localparam int CNT_W    = (SAMC_W > $clog2(CNV_TICKS)) ? SAMC_W : $clog2(CNV_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp,
  input  logic              is_auto,
  input  logic              trig,
  input  logic              tick,
  input  logic [SAMC_W-1:0] samp_cnt,
  output phase_e            phase,
  output logic              phase_start,
  output logic              acq_start,
  output logic              samp_expire,
  output logic              conv_done
);

  // Acquisition length in ticks, never less than one.
  function automatic logic [CNT_W-1:0] samp_len(input logic [SAMC_W-1:0] v);
    samp_len = (v == '0) ? CNT_W'(1) : CNT_W'(v);
  endfunction

  phase_e            nxt;
  logic [CNT_W-1:0]  tcnt;
  logic [CNT_W-1:0]  samp_last;

  assign samp_last   = samp_len(samp_cnt) - CNT_W'(1);
  assign samp_expire = (phase == PH_SAMPLE) && tick && (tcnt == samp_last);
  assign conv_done   = en && (phase == PH_CONVERT) && tick &&
                       (tcnt == CNT_W'(CNV_TICKS - 1));

  always_comb begin
    nxt = phase;
    if (!en) begin
      nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:    if (samp || is_auto) nxt = PH_SAMPLE;
        PH_SAMPLE:  if (trig) nxt = PH_CONVERT;
        PH_CONVERT: if (conv_done) nxt = is_auto ? PH_SAMPLE : PH_IDLE;
        default:    nxt = PH_IDLE;
      endcase
    end
  end

  assign phase_start = (nxt != phase);
  assign acq_start   = (phase == PH_IDLE) && (nxt == PH_SAMPLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
    end else begin
      phase <= nxt;
      if (phase_start || phase == PH_IDLE) begin
        tcnt <= '0;
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int SAMC_W    = 5,
  parameter int ADCS_W    = 6,
  parameter int CNV_TICKS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              samp_i,
  input  logic [2:0]        src_i,
  input  logic [SAMC_W-1:0] samp_cnt_i,
  input  logic [ADCS_W-1:0] clk_sel_i,
  input  logic              tmr_evt_i,
  input  logic              ext_evt_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              buf_wr_i,
  input  logic [RES_W-1:0]  buf_wdata_i,
  output logic [RES_W-1:0]  buf_o,
  output logic              done_pulse_o,
  output logic              done_o,
  output logic              sampling_o,
  output logic              converting_o
);

  // Named internal events, used by the bound checker.
  phase_e phase;
  logic   phase_start;
  logic   acq_start;
  logic   samp_expire;
  logic   conv_done;
  logic   conv_tick;
  logic   is_auto;
  logic   trig_fire;
  logic   auto_start;
  logic   div_run;

  assign sampling_o   = (phase == PH_SAMPLE);
  assign converting_o = (phase == PH_CONVERT);
  assign div_run      = sampling_o || converting_o;

  adc_clkdiv #(.ADCS_W(ADCS_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_run),
    .restart (phase_start),
    .clk_sel (clk_sel_i),
    .tick    (conv_tick)
  );

  adc_trig_sel u_sel (
    .src         (src_i),
    .sampling    (sampling_o),
    .samp        (samp_i),
    .tmr_evt     (tmr_evt_i),
    .ext_evt     (ext_evt_i),
    .samp_expire (samp_expire),
    .is_auto     (is_auto),
    .trig        (trig_fire),
    .auto_start  (auto_start)
  );

  adc_seq_fsm #(.SAMC_W(SAMC_W), .CNV_TICKS(CNV_TICKS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_i),
    .samp        (samp_i),
    .is_auto     (is_auto),
    .trig        (trig_fire),
    .tick        (conv_tick),
    .samp_cnt    (samp_cnt_i),
    .phase       (phase),
    .phase_start (phase_start),
    .acq_start   (acq_start),
    .samp_expire (samp_expire),
    .conv_done   (conv_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_o        <= '0;
      done_pulse_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_pulse_o <= conv_done;
      if (conv_done) begin
        buf_o <= conv_data_i;
      end else if (buf_wr_i) begin
        buf_o <= buf_wdata_i;
      end
      if (conv_done) begin
        done_o <= 1'b1;
      end else if (acq_start) begin
        done_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
  parameter int RES_W     = 10,
  parameter int ADCS_W    = 6,
  parameter int CNV_TICKS = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [ADCS_W-1:0] clk_sel_i,
  input logic [RES_W-1:0]  conv_data_i,
  input logic              buf_wr_i,
  input logic [RES_W-1:0]  buf_o,
  input logic              done_pulse_o,
  input logic              done_o,
  input logic              sampling_o,
  input logic              converting_o,
  input logic              conv_done,
  input logic              auto_start
);

  logic [15:0] conv_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n || !converting_o) conv_cyc <= '0;
    else                         conv_cyc <= conv_cyc + 1'b1;
  end

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampling_o && converting_o));

  a_r1_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sampling_o && !converting_o));

  a_r2_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (int'(conv_cyc) == CNV_TICKS * (int'(clk_sel_i) + 1) - 1));

  a_r7_result_latched: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (done_pulse_o && buf_o == $past(conv_data_i)));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |=> !done_pulse_o);

  a_r8_abort_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !buf_wr_i) |=> ($stable(buf_o) && !done_pulse_o));

  a_r9_clear_beats_autostart: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_start && !en_i) |=> !converting_o);

  a_r10_sticky_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |-> done_o);

endmodule

bind adc_trig_seq adc_trig_seq_chk #(
  .RES_W     (RES_W),
  .ADCS_W    (ADCS_W),
  .CNV_TICKS (CNV_TICKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .clk_sel_i    (clk_sel_i),
  .conv_data_i  (conv_data_i),
  .buf_wr_i     (buf_wr_i),
  .buf_o        (buf_o),
  .done_pulse_o (done_pulse_o),
  .done_o       (done_o),
  .sampling_o   (sampling_o),
  .converting_o (converting_o),
  .conv_done    (conv_done),
  .auto_start   (auto_start)
);

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i, samp_i, tmr_evt_i, ext_evt_i, buf_wr_i;
  logic [2:0] src_i;
  logic [4:0] samp_cnt_i;
  logic [5:0] clk_sel_i;
  logic [9:0] conv_data_i, buf_wdata_i, buf_o;
  logic       done_pulse_o, done_o, sampling_o, converting_o;

  always #2 clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .samp_i(samp_i), .src_i(src_i),
    .samp_cnt_i(samp_cnt_i), .clk_sel_i(clk_sel_i), .tmr_evt_i(tmr_evt_i),
    .ext_evt_i(ext_evt_i), .conv_data_i(conv_data_i), .buf_wr_i(buf_wr_i),
    .buf_wdata_i(buf_wdata_i), .buf_o(buf_o), .done_pulse_o(done_pulse_o),
    .done_o(done_o), .sampling_o(sampling_o), .converting_o(converting_o)
  );

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always @(negedge clk) if (rst_n && done_pulse_o) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until done_pulse_o is seen; returns lim+1 on timeout.
  task automatic wait_done(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done_pulse_o) return;
    end
    n = lim + 1;
  endtask

  task automatic go_idle();
    en_i = 0; samp_i = 0; tmr_evt_i = 0; ext_evt_i = 0; buf_wr_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, p, s, pc;
    rst_n = 0; en_i = 0; samp_i = 0; src_i = 0; samp_cnt_i = 0; clk_sel_i = 0;
    tmr_evt_i = 0; ext_evt_i = 0; conv_data_i = 0; buf_wr_i = 0; buf_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(buf_o == 0 && !done_o && !done_pulse_o && !sampling_o && !converting_o,
        "R1 reset", int'(buf_o), 0);

    // Auto-mode sweep over divider and sample count (R2, R5, R6, R7, R10).
    for (int sel = 0; sel < 5; sel++) begin
      for (int sc = 0; sc < 4; sc++) begin
        go_idle();
        p = sel + 1;
        s = (sc == 0) ? 1 : sc;
        src_i = 3'b111; clk_sel_i = 6'(sel); samp_cnt_i = 5'(sc);
        conv_data_i = 10'(sel * 37 + sc * 5 + 1);
        en_i = 1;
        wait_done(2000, n);
        chk(n == 1 + (s + 14) * p, (sc == 0) ? "R6 first latency" : "R5 first latency",
            n, 1 + (s + 14) * p);
        chk(buf_o == 10'(sel * 37 + sc * 5 + 1), "R7 buffer", int'(buf_o), sel * 37 + sc * 5 + 1);
        conv_data_i = 10'(sel * 37 + sc * 5 + 500);
        wait_done(2000, n);
        chk(n == (s + 14) * p, "R5 back-to-back period", n, (s + 14) * p);
        chk(buf_o == 10'(sel * 37 + sc * 5 + 500), "R7 second buffer",
            int'(buf_o), sel * 37 + sc * 5 + 500);
        chk(done_o == 1, "R10 sticky through auto", int'(done_o), 1);
        en_i = 0;
        @(negedge clk);
        chk(!sampling_o && !converting_o, "R1 disable idles",
            int'({sampling_o, converting_o}), 0);
      end
    end

    // Software trigger (R3, R2, R10).
    go_idle();
    src_i = 3'b000; clk_sel_i = 6'd2; samp_i = 1; en_i = 1;
    @(negedge clk);
    chk(sampling_o == 1, "R3 acquisition on sample bit", int'(sampling_o), 1);
    chk(done_o == 0, "R10 cleared on acquisition", int'(done_o), 0);
    repeat (5) @(negedge clk);
    chk(converting_o == 0, "R3 holds while sample high", int'(converting_o), 0);
    conv_data_i = 10'h155;
    samp_i = 0;
    wait_done(2000, n);
    chk(n == 1 + 14 * 3, "R2 conversion length", n, 43);
    chk(buf_o == 10'h155, "R3 software result", int'(buf_o), 'h155);
    repeat (3) @(negedge clk);
    chk(!sampling_o && !converting_o, "R3 idles after result",
        int'({sampling_o, converting_o}), 0);

    // Timer source ignores the external pulse, then fires on the timer (R4).
    go_idle();
    src_i = 3'b010; samp_i = 1; en_i = 1; conv_data_i = 10'h0A7;
    repeat (3) @(negedge clk);
    pc = pulses;
    ext_evt_i = 1; @(negedge clk); ext_evt_i = 0;
    repeat (60) @(negedge clk);
    chk(sampling_o && !converting_o && pulses == pc, "R4 timer ignores external",
        pulses - pc, 0);
    tmr_evt_i = 1; @(negedge clk); tmr_evt_i = 0;
    wait_done(2000, n);
    chk(n == 14 * 3, "R4 timer trigger", n + 1, 43);
    chk(buf_o == 10'h0A7, "R4 timer result", int'(buf_o), 'h0A7);

    // External source ignores the timer pulse, then fires on external (R4).
    go_idle();
    src_i = 3'b001; samp_i = 1; en_i = 1; conv_data_i = 10'h31E;
    repeat (3) @(negedge clk);
    pc = pulses;
    tmr_evt_i = 1; @(negedge clk); tmr_evt_i = 0;
    repeat (60) @(negedge clk);
    chk(sampling_o && !converting_o && pulses == pc, "R4 external ignores timer",
        pulses - pc, 0);
    ext_evt_i = 1; @(negedge clk); ext_evt_i = 0;
    wait_done(2000, n);
    chk(n == 14 * 3, "R4 external trigger", n + 1, 43);

    // Reserved codes never trigger (R4).
    for (int code = 3; code < 7; code++) begin
      go_idle();
      src_i = 3'(code); samp_i = 1; en_i = 1;
      repeat (2) @(negedge clk);
      pc = pulses;
      tmr_evt_i = 1; ext_evt_i = 1; samp_i = 0;
      repeat (3) @(negedge clk);
      tmr_evt_i = 0; ext_evt_i = 0;
      repeat (60) @(negedge clk);
      chk(!converting_o && pulses == pc, "R4 reserved code", pulses - pc, 0);
    end

    // Direct buffer write, then an aborted conversion keeps it (R11, R8).
    go_idle();
    buf_wdata_i = 10'h2AA; buf_wr_i = 1; @(negedge clk); buf_wr_i = 0;
    @(negedge clk);
    chk(buf_o == 10'h2AA, "R11 direct write", int'(buf_o), 'h2AA);
    src_i = 3'b111; clk_sel_i = 6'd1; samp_cnt_i = 5'd1; conv_data_i = 10'h0F0;
    pc = pulses;
    en_i = 1;
    repeat (10) @(negedge clk);
    chk(converting_o == 1, "R8 conversion underway", int'(converting_o), 1);
    en_i = 0;
    repeat (40) @(negedge clk);
    chk(buf_o == 10'h2AA, "R8 abort keeps buffer", int'(buf_o), 'h2AA);
    chk(pulses == pc && !converting_o, "R8 no done after abort", pulses - pc, 0);

    // Enable clear coinciding with the automatic start (R9).
    go_idle();
    clk_sel_i = 6'd0; samp_cnt_i = 5'd2; pc = pulses;
    en_i = 1;
    repeat (2) @(negedge clk);
    en_i = 0;
    @(negedge clk);
    chk(!converting_o && !sampling_o, "R9 clear beats auto-start",
        int'({sampling_o, converting_o}), 0);
    repeat (30) @(negedge clk);
    chk(pulses == pc && buf_o == 10'h2AA, "R9 no result", int'(buf_o), 'h2AA);
    go_idle();
    en_i = 1;
    repeat (3) @(negedge clk);
    chk(converting_o == 1, "R9 control one cycle later", int'(converting_o), 1);
    en_i = 0;

    // Direct write in the completing cycle loses to the result (R11).
    go_idle();
    src_i = 3'b000; clk_sel_i = 6'd0; samp_i = 1; en_i = 1; conv_data_i = 10'h1A5;
    @(negedge clk);
    samp_i = 0;
    repeat (14) @(negedge clk);
    buf_wdata_i = 10'h3C3; buf_wr_i = 1;
    @(negedge clk);
    buf_wr_i = 0;
    chk(done_pulse_o == 1, "R2 completion cycle", int'(done_pulse_o), 1);
    chk(buf_o == 10'h1A5, "R11 result beats write", int'(buf_o), 'h1A5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule